// File: doc/BRIEF.md
# USB Host Controller Interrupt Register Block

This block keeps the interrupt state of a USB host controller. Internal event sources (start of frame, done-queue writeback, root hub change, scheduling overrun and the rest) each raise a one-cycle pulse on their own bit of a set vector. The pulse latches into a sticky status register. A 32-bit enable register selects which status bits may interrupt. Bit 31 of the enable register is a master gate over all of them. A registered level output goes high while the master gate is open and at least one enabled status bit is pending.

Software reaches the block through a simple word-wide register bus: a write strobe, a word address, write data and combinational read data. The enable register has two write addresses. One ORs the written ones into the enable and the other clears them. Both addresses read back the same enable value. The status register is cleared by writing ones. Routing the output to a system interrupt controller is left to the surrounding logic.

Top module: `usbh_irq_regs`

## Requirements
- R1: After reset the status register reads 0x0000_0000, the enable register reads 0x8000_0000 (master gate only), and `irq_o` is low.
- R2: A one on bit b of `src_set_i` sets status bit b at the next clock edge, and the bit then stays set. Only bits 0 to 6 and bit 30 exist (0 overrun, 1 done writeback, 2 start of frame, 3 resume, 4 fatal error, 5 frame counter wrap, 6 hub change, 30 ownership change). Pulses on any other bit leave status reading 0 there.
- R3: A write to word address 0 (status) clears every status bit written as 1. Bits written as 0 keep their value.
- R4: A write to word address 1 (enable-set) ORs the write data into the enable register. Only bits 0 to 6, 30 and 31 exist.
- R5: A write to word address 2 (enable-clear) clears every enable bit written as 1. Bits written as 0 keep their value.
- R6: Reads of address 1 and address 2 both return the current enable value. A read of address 0 returns status.
- R7: `irq_o` is high when enable bit 31 is set and (status AND enable) is nonzero in bits 0 to 30. It follows a change of status or enable one clock edge after the register itself changes.
- R8: When a source pulse and a software clear hit the same status bit in the same cycle, the bit ends up set.
- R9: With enable bit 31 clear, `irq_o` stays low even while enabled status bits are pending.
- R10: Address 3 reads as zero, and a write to it changes neither status nor enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| src_set_i | input | 32 | One-cycle set pulses from the interrupt sources, one per status bit |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Word address: 0 status, 1 enable-set, 2 enable-clear |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Combinational read data for `reg_addr_i` |
| irq_o | output | 1 | Registered level interrupt |

## Verification
A status bit that fails to latch, or a clear that fails to take effect, shows on the status read the cycle after the pulse or write. It also shows on `irq_o` one edge later, once the bit is enabled. A wrong enable value shows identically on both enable addresses. It also moves `irq_o` one edge after the write. A lost master gate or a missing pipeline stage shows as `irq_o` changing on the wrong edge. The directed cases look at both edges around each change, so an off-by-one in the output stage is seen at once.

// File: rtl/usbh_irq_pkg.sv
package usbh_irq_pkg;
  localparam int unsigned DATA_W   = 32;
  localparam int unsigned ADDR_W   = 2;
  localparam int unsigned MIE_BIT  = 31;

  localparam logic [ADDR_W-1:0] A_STAT   = 2'd0;
  localparam logic [ADDR_W-1:0] A_EN_SET = 2'd1;
  localparam logic [ADDR_W-1:0] A_EN_CLR = 2'd2;

  // implemented status sources: bits 0..6 and 30
  localparam logic [DATA_W-1:0] STAT_MASK = 32'h4000_007F;
  localparam logic [DATA_W-1:0] EN_MASK   = STAT_MASK | (32'h1 << MIE_BIT);
  localparam logic [DATA_W-1:0] EN_RST    = 32'h1 << MIE_BIT;
endpackage

// File: rtl/usbh_irq_status.sv
module usbh_irq_status #(
  parameter int unsigned DATA_W = 32,
  parameter logic [DATA_W-1:0] MASK = '1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] set_i,
  input  logic              clr_we_i,
  input  logic [DATA_W-1:0] clr_i,
  output logic [DATA_W-1:0] stat_o
);
  logic [DATA_W-1:0] stat_q, clr_v, set_v;

  assign set_v = set_i & MASK;
  assign clr_v = clr_we_i ? clr_i : '0;

  // set wins over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stat_q <= '0;
    else         stat_q <= ((stat_q & ~clr_v) | set_v) & MASK;
  end

  assign stat_o = stat_q;

  p_set_sticks_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|set_v) |=> ((stat_q & $past(set_v)) == $past(set_v)));
  p_w1c_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(clr_v & ~set_v)) |=> ((stat_q & $past(clr_v & ~set_v)) == '0));
  p_set_over_clr_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(clr_v & set_v)) |=> ((stat_q & $past(clr_v & set_v)) == $past(clr_v & set_v)));
endmodule

// File: rtl/usbh_irq_enable.sv
module usbh_irq_enable #(
  parameter int unsigned DATA_W = 32,
  parameter logic [DATA_W-1:0] MASK = '1,
  parameter logic [DATA_W-1:0] RST  = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              set_we_i,
  input  logic              clr_we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] en_o
);
  logic [DATA_W-1:0] en_q, or_v, andn_v;

  assign or_v   = set_we_i ? wdata_i : '0;
  assign andn_v = clr_we_i ? wdata_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_q <= RST;
    else         en_q <= ((en_q | or_v) & ~andn_v) & MASK;
  end

  assign en_o = en_q;

  p_en_set_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_we_i |=> ((en_q & $past(wdata_i & MASK)) == $past(wdata_i & MASK)));
  p_en_clr_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_we_i |=> ((en_q & $past(wdata_i)) == '0));
endmodule

// File: rtl/usbh_irq_out.sv
module usbh_irq_out #(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned MIE_BIT = 31
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] stat_i,
  input  logic [DATA_W-1:0] en_i,
  output logic              irq_o
);
  localparam logic [DATA_W-1:0] SRC_MASK = ~(DATA_W'(1) << MIE_BIT);

  logic pend, irq_q;

  assign pend = |(stat_i & en_i & SRC_MASK);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= en_i[MIE_BIT] & pend;
  end

  assign irq_o = irq_q;

  p_mie_gate_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i[MIE_BIT] |=> !irq_o);
  p_no_pend_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((stat_i & en_i & SRC_MASK) == '0) |=> !irq_o);
endmodule

// File: rtl/usbh_irq_regs.sv
module usbh_irq_regs
  import usbh_irq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] src_set_i,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              irq_o
);
  logic [DATA_W-1:0] stat, en;
  logic stat_we, en_set_we, en_clr_we;

  assign stat_we   = reg_we_i && (reg_addr_i == A_STAT);
  assign en_set_we = reg_we_i && (reg_addr_i == A_EN_SET);
  assign en_clr_we = reg_we_i && (reg_addr_i == A_EN_CLR);

  usbh_irq_status #(.DATA_W(DATA_W), .MASK(STAT_MASK)) u_status (
    .clk_i, .rst_ni,
    .set_i    (src_set_i),
    .clr_we_i (stat_we),
    .clr_i    (reg_wdata_i),
    .stat_o   (stat)
  );

  usbh_irq_enable #(.DATA_W(DATA_W), .MASK(EN_MASK), .RST(EN_RST)) u_enable (
    .clk_i, .rst_ni,
    .set_we_i (en_set_we),
    .clr_we_i (en_clr_we),
    .wdata_i  (reg_wdata_i),
    .en_o     (en)
  );

  usbh_irq_out #(.DATA_W(DATA_W), .MIE_BIT(MIE_BIT)) u_out (
    .clk_i, .rst_ni,
    .stat_i (stat),
    .en_i   (en),
    .irq_o  (irq_o)
  );

  always_comb begin
    unique case (reg_addr_i)
      A_STAT:             reg_rdata_o = stat;
      A_EN_SET, A_EN_CLR: reg_rdata_o = en;
      default:            reg_rdata_o = '0;
    endcase
  end

  p_reset_en_r1: assert property (@(posedge clk_i)
    $rose(rst_ni) |-> (en == EN_RST && stat == '0 && !irq_o));
  p_unmapped_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i == 2'd3 && src_set_i == '0) |=> ($stable(stat) && $stable(en)));
endmodule

// File: tb/usbh_irq_regs_tb_top.sv
module usbh_irq_regs_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] src_set_i = '0;
  logic        reg_we_i = 1'b0;
  logic [1:0]  reg_addr_i = '0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic        irq_o;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #5 clk_i = ~clk_i;

  usbh_irq_regs dut_i (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic rd(logic [1:0] a, output logic [31:0] d);
    reg_addr_i = a;
    #1 d = reg_rdata_o;
  endtask

  task automatic chk_rd(string req, logic [1:0] a, logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    chk(req, d, exp);
  endtask

  // drive at negedge, register updates at next posedge, back at negedge
  task automatic wr(logic [1:0] a, logic [31:0] d, logic [31:0] src = '0);
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d; src_set_i = src;
    @(negedge clk_i);
    reg_we_i = 1'b0; reg_wdata_i = '0; src_set_i = '0;
  endtask

  task automatic pulse(logic [31:0] src);
    src_set_i = src;
    @(negedge clk_i);
    src_set_i = '0;
  endtask

  task automatic t_reset;
    chk_rd("R1 status", 2'd0, 32'h0);
    chk_rd("R1 enable", 2'd1, 32'h8000_0000);
    chk("R1 irq", {31'b0, irq_o}, 32'h0);
  endtask

  task automatic t_sources;
    pulse(32'h0000_0004);
    chk_rd("R2 sof bit", 2'd0, 32'h0000_0004);
    @(negedge clk_i);
    chk("R7 not enabled", {31'b0, irq_o}, 32'h0);
    pulse(32'hFFFF_FFFF);
    chk_rd("R2 only implemented bits", 2'd0, 32'h4000_007F);
    @(negedge clk_i);
    chk_rd("R2 sticky", 2'd0, 32'h4000_007F);
  endtask

  task automatic t_w1c;
    wr(2'd0, 32'h0000_0005);
    chk_rd("R3 w1c", 2'd0, 32'h4000_007A);
    wr(2'd0, 32'h0);
    chk_rd("R3 zero write", 2'd0, 32'h4000_007A);
  endtask

  task automatic t_enable;
    wr(2'd1, 32'h0000_0008);
    chk_rd("R4 or set", 2'd1, 32'h8000_0008);
    chk_rd("R6 clr addr reads enable", 2'd2, 32'h8000_0008);
    chk("R7 one edge later, still low", {31'b0, irq_o}, 32'h0);
    @(negedge clk_i);
    chk("R7 irq high", {31'b0, irq_o}, 32'h1);
  endtask

  task automatic t_master;
    wr(2'd2, 32'h8000_0000);
    chk_rd("R5 clr mie", 2'd1, 32'h0000_0008);
    @(negedge clk_i);
    chk("R9 gated low", {31'b0, irq_o}, 32'h0);
    wr(2'd1, 32'h8000_0000);
    @(negedge clk_i);
    chk("R9 ungated high", {31'b0, irq_o}, 32'h1);
    wr(2'd2, 32'h0000_0008);
    chk_rd("R5 clr src en", 2'd2, 32'h8000_0000);
    @(negedge clk_i);
    chk("R7 low after disable", {31'b0, irq_o}, 32'h0);
  endtask

  task automatic t_collide;
    wr(2'd0, 32'hFFFF_FFFF);
    chk_rd("R3 clear all", 2'd0, 32'h0);
    pulse(32'h0000_0002);
    wr(2'd0, 32'h0000_0002, 32'h0000_0002);
    chk_rd("R8 set wins", 2'd0, 32'h0000_0002);
  endtask

  task automatic t_unmapped;
    wr(2'd3, 32'hFFFF_FFFF);
    chk_rd("R10 status kept", 2'd0, 32'h0000_0002);
    chk_rd("R10 enable kept", 2'd1, 32'h8000_0000);
    chk_rd("R10 reads zero", 2'd3, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_sources();
    t_w1c();
    t_enable();
    t_master();
    t_collide();
    t_unmapped();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (10000) @(posedge clk_i);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule